// File: doc/BRIEF.md
# Bus Cycle Start Sequencer

This block sits in the bus interface of a processor. It decides in which clock a new bus cycle may begin. When it starts a cycle it pulses a one-clock address strobe. In that same clock it puts the address and the cycle-definition code of the winning requester onto the bus outputs, and it returns a one-clock "issued" acknowledge to that requester. Two requesters feed it: ordinary memory or I/O cycles, and writebacks of modified lines that snoop hits cause. The system side drives handshake inputs: burst ready (ends the current cycle), address hold, back-off, hold acknowledge, reset, init, and the hit-modified indication of a snoop.

Each of these events imposes its own spacing before the next strobe. The sequencer keeps a small down-counter for each timing rule. It also keeps a busy flag that stays set from the strobe until burst ready arrives. A separate output-enable tells the pad logic when the strobe and the cycle outputs must be floated, for example while another master owns the bus. Address generation, data transfer and burst counting live elsewhere.

Top module: `bus_start_seq`

## Requirements
- R1: `strobe` is high for exactly one clock per started cycle. It is never high in two consecutive clocks.
- R2: When `burst_rdy` is high in clock t, `strobe` stays low in clock t+1. A pending request may be strobed in clock t+2.
- R3: When `back_off`, `hold_ack` or `addr_hold` is first sampled low in clock t after being high, no cycle that the signal blocked is strobed in clock t. Such a cycle may be strobed in clock t+1.
- R4: A snoop writeback (`req_wb`) is never strobed in the clock where `hit_mod` rises, nor in the next clock. It may be strobed two clocks after the rise.
- R5: While `addr_hold` is high, no ordinary request is strobed. A pending snoop writeback can still be strobed.
- R6: `strobe` is low in every clock where `back_off`, `hold_ack`, `rst` or `cpu_init` is high. Dropping `cpu_init` adds no spacing.
- R7: `strobe_oe` is low (floated) in the clock where `hold_ack` is high. It is also low in the clock after any clock where `back_off` is high. In all other clocks after reset it is high.
- R8: In the strobe clock, `bus_addr`/`bus_def` carry the winner's address and code. For a writeback, the low `LINE_LSB` address bits read zero (line alignment; 5 by default). The outputs then hold those values until the next strobe.
- R9: When a writeback and an ordinary request are both eligible in the same clock, the writeback wins.
- R10: In each strobe clock, exactly one of `issued_nrm`/`issued_wb` pulses, and neither pulses outside strobe clocks. After a strobe, no further strobe happens until `burst_rdy` has ended the cycle.
- R11: While `rst` is high, `strobe` and `strobe_oe` are low. Reset clears the busy flag and all spacing counters, so a request present in the first clock after reset is strobed at once. It also clears the held bus address and code to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_init | input | 1 | Init request; blocks strobes while high |
| req_nrm | input | 1 | Ordinary memory/I/O cycle pending |
| req_wb | input | 1 | Snoop writeback pending |
| nrm_addr | input | AW | Address of the ordinary request |
| nrm_def | input | CW | Cycle-definition code of the ordinary request |
| wb_addr | input | AW | Address of the writeback line |
| wb_def | input | CW | Cycle-definition code of the writeback |
| burst_rdy | input | 1 | Last data transfer of the current cycle |
| addr_hold | input | 1 | Address hold from system logic |
| back_off | input | 1 | Back-off from system logic |
| hold_ack | input | 1 | Bus hold acknowledge |
| hit_mod | input | 1 | Snoop hit on a modified line |
| strobe | output | 1 | One-clock bus cycle start strobe |
| strobe_oe | output | 1 | Output enable for strobe and cycle outputs |
| bus_addr | output | AW | Address driven for the cycle |
| bus_def | output | CW | Cycle-definition code driven for the cycle |
| issued_nrm | output | 1 | Ordinary request issued (strobe clock) |
| issued_wb | output | 1 | Writeback issued (strobe clock) |

## Verification
A busy flag stuck high freezes the bus. The next pending request never gets a strobe, and the first check after a burst ready shows this. A busy flag stuck low gives a second strobe in the clock after the first. A spacing counter that is loaded one short, or that is not reloaded, lets a strobe appear exactly one clock early: right after burst ready, a release, or a hit-modified rise. The bench therefore samples each of those first eligible clocks and the one before it. Wrong output-enable timing shows in the clock of `hold_ack` or the clock after `back_off`. A wrong alignment mask or a lost hold register shows on `bus_addr` in or just after a strobe clock.

// File: rtl/bss_pkg.sv
package bss_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_NRM  = 2'd1,
      SRC_WB   = 2'd2
   } src_e;

   // release-spacing inputs, one timer each
   localparam int REL_N  = 3;
   localparam int REL_AH = 0;   // address hold
   localparam int REL_BO = 1;   // back-off
   localparam int REL_HA = 2;   // hold acknowledge

endpackage

// File: rtl/bss_gap_timer.sv
// Blocks an action from the clock a trigger is seen until GAP clocks later.
module bss_gap_timer #(
   parameter int GAP = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig,
   output logic blocked
);
   localparam int CNTW = (GAP < 2) ? 1 : $clog2(GAP + 1);
   localparam logic [CNTW-1:0] LOADV = CNTW'(GAP - 1);

   generate
      if (GAP < 1) begin : g_bad_gap
         $error("bss_gap_timer: GAP must be at least 1");
      end
   endgenerate

   logic [CNTW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (trig)
         cnt <= LOADV;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign blocked = trig | (cnt != '0);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= LOADV);

   generate
      if (GAP > 1) begin : g_hold_chk
         // R2
         gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
            trig |=> blocked);
      end
   endgenerate

endmodule

// File: rtl/bss_arbiter.sv
// Picks the requester that starts the next cycle.
module bss_arbiter #(
   parameter bit WB_FIRST = 1'b1
) (
   input  logic           base_ok,
   input  logic           nrm_hold,
   input  logic           wb_gap,
   input  logic           req_nrm,
   input  logic           req_wb,
   output bss_pkg::src_e  sel,
   output logic           fire
);
   logic nrm_ok;
   logic wb_ok;

   assign nrm_ok = base_ok & req_nrm & ~nrm_hold;
   assign wb_ok  = base_ok & req_wb  & ~wb_gap;

   generate
      if (WB_FIRST) begin : g_wb_first
         always_comb begin
            if (wb_ok)       sel = bss_pkg::SRC_WB;
            else if (nrm_ok) sel = bss_pkg::SRC_NRM;
            else             sel = bss_pkg::SRC_NONE;
         end
      end else begin : g_nrm_first
         always_comb begin
            if (nrm_ok)      sel = bss_pkg::SRC_NRM;
            else if (wb_ok)  sel = bss_pkg::SRC_WB;
            else             sel = bss_pkg::SRC_NONE;
         end
      end
   endgenerate

   assign fire = (sel != bss_pkg::SRC_NONE);

   // R6
   always_comb begin
      pick_legal_chk: assert (!fire || base_ok);
   end

endmodule

// File: rtl/bss_addr_drive.sv
// Drives address and cycle code in the strobe clock, then holds them.
module bss_addr_drive #(
   parameter int AW       = 32,
   parameter int CW       = 4,
   parameter int LINE_LSB = 5
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           fire,
   input  bss_pkg::src_e  sel,
   input  logic [AW-1:0]  nrm_addr,
   input  logic [CW-1:0]  nrm_def,
   input  logic [AW-1:0]  wb_addr,
   input  logic [CW-1:0]  wb_def,
   output logic [AW-1:0]  bus_addr,
   output logic [CW-1:0]  bus_def
);
   localparam logic [AW-1:0] WB_MASK = ~((AW'(1) << LINE_LSB) - AW'(1));

   logic [AW-1:0] addr_q;
   logic [CW-1:0] def_q;
   logic [AW-1:0] pick_addr;
   logic [CW-1:0] pick_def;

   always_comb begin
      if (sel == bss_pkg::SRC_WB) begin
         pick_addr = wb_addr & WB_MASK;
         pick_def  = wb_def;
      end else begin
         pick_addr = nrm_addr;
         pick_def  = nrm_def;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         def_q  <= '0;
      end else if (fire) begin
         addr_q <= pick_addr;
         def_q  <= pick_def;
      end
   end

   assign bus_addr = fire ? pick_addr : addr_q;
   assign bus_def  = fire ? pick_def  : def_q;

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!fire && !$past(rst)) |-> ($stable(bus_addr) && $stable(bus_def)));

   generate
      if (LINE_LSB > 0) begin : g_align_chk
         // R8
         wb_align_chk: assert property (@(posedge clk) disable iff (rst)
            (fire && sel == bss_pkg::SRC_WB) |-> (bus_addr[LINE_LSB-1:0] == '0));
      end
   endgenerate

endmodule

// File: rtl/bus_start_seq.sv
module bus_start_seq #(
   parameter int AW       = 32,
   parameter int CW       = 4,
   parameter int LINE_LSB = 5,
   parameter int RDY_GAP  = 2,
   parameter int REL_GAP  = 1,
   parameter int HIT_GAP  = 2,
   parameter bit WB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cpu_init,
   input  logic          req_nrm,
   input  logic          req_wb,
   input  logic [AW-1:0] nrm_addr,
   input  logic [CW-1:0] nrm_def,
   input  logic [AW-1:0] wb_addr,
   input  logic [CW-1:0] wb_def,
   input  logic          burst_rdy,
   input  logic          addr_hold,
   input  logic          back_off,
   input  logic          hold_ack,
   input  logic          hit_mod,
   output logic          strobe,
   output logic          strobe_oe,
   output logic [AW-1:0] bus_addr,
   output logic [CW-1:0] bus_def,
   output logic          issued_nrm,
   output logic          issued_wb
);
   import bss_pkg::*;

   // a release trigger is the last high clock; the first strobe clock
   // lies REL_GAP clocks after the first low clock
   localparam int REL_TGAP = REL_GAP + 1;

   generate
      if (LINE_LSB >= AW) begin : g_bad_lsb
         $error("bus_start_seq: LINE_LSB must be below AW");
      end
      if (AW < 1 || CW < 1) begin : g_bad_width
         $error("bus_start_seq: AW and CW must be positive");
      end
   endgenerate

   logic             busy;
   logic             bo_q;
   logic             hit_q;
   logic             rdy_blk;
   logic             hit_blk;
   logic             base_ok;
   logic             fire;
   src_e             sel;
   logic [REL_N-1:0] rel_in;
   logic [REL_N-1:0] rel_blk;

   // cycle in flight: from strobe until burst ready
   always_ff @(posedge clk) begin
      if (rst)
         busy <= 1'b0;
      else if (fire)
         busy <= 1'b1;
      else if (burst_rdy)
         busy <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bo_q  <= 1'b0;
         hit_q <= 1'b0;
      end else begin
         bo_q  <= back_off;
         hit_q <= hit_mod;
      end
   end

   bss_gap_timer #(.GAP(RDY_GAP)) u_rdy_gap (
      .clk(clk), .rst(rst), .trig(burst_rdy), .blocked(rdy_blk)
   );

   bss_gap_timer #(.GAP(HIT_GAP)) u_hit_gap (
      .clk(clk), .rst(rst), .trig(hit_mod & ~hit_q), .blocked(hit_blk)
   );

   always_comb begin
      rel_in         = '0;
      rel_in[REL_AH] = addr_hold;
      rel_in[REL_BO] = back_off;
      rel_in[REL_HA] = hold_ack;
   end

   generate
      for (genvar gi = 0; gi < REL_N; gi++) begin : g_rel
         bss_gap_timer #(.GAP(REL_TGAP)) u_rel_gap (
            .clk(clk), .rst(rst), .trig(rel_in[gi]), .blocked(rel_blk[gi])
         );
      end
   endgenerate

   assign base_ok = ~busy & ~rst & ~cpu_init & ~rdy_blk
                  & ~rel_blk[REL_BO] & ~rel_blk[REL_HA];

   bss_arbiter #(.WB_FIRST(WB_FIRST)) u_arb (
      .base_ok (base_ok),
      .nrm_hold(rel_blk[REL_AH]),
      .wb_gap  (hit_blk),
      .req_nrm (req_nrm),
      .req_wb  (req_wb),
      .sel     (sel),
      .fire    (fire)
   );

   bss_addr_drive #(.AW(AW), .CW(CW), .LINE_LSB(LINE_LSB)) u_drv (
      .clk     (clk),
      .rst     (rst),
      .fire    (fire),
      .sel     (sel),
      .nrm_addr(nrm_addr),
      .nrm_def (nrm_def),
      .wb_addr (wb_addr),
      .wb_def  (wb_def),
      .bus_addr(bus_addr),
      .bus_def (bus_def)
   );

   assign strobe     = fire;
   assign issued_nrm = fire & (sel == SRC_NRM);
   assign issued_wb  = fire & (sel == SRC_WB);
   assign strobe_oe  = ~(rst | hold_ack | bo_q);

   // R1
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);

   // R2
   rdy_space_chk: assert property (@(posedge clk) disable iff (rst)
      $past(burst_rdy) |-> !strobe);

   // R3
   release_space_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(back_off) || $fell(hold_ack)) |-> !strobe);

   // R3
   ah_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(addr_hold) |-> !issued_nrm);

   // R4
   hit_same_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hit_mod) |-> !issued_wb);

   // R4
   hit_next_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hit_mod) |=> !issued_wb);

   // R5
   ah_nrm_chk: assert property (@(posedge clk) disable iff (rst)
      addr_hold |-> !issued_nrm);

   // R6
   blocked_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_init || back_off || hold_ack) |-> !strobe);

   // R7
   hla_float_chk: assert property (@(posedge clk) disable iff (rst)
      hold_ack |-> !strobe_oe);

   // R7
   bo_float_chk: assert property (@(posedge clk) disable iff (rst)
      $past(back_off) |-> !strobe_oe);

   // R10
   issue_one_chk: assert property (@(posedge clk) disable iff (rst)
      strobe == (issued_nrm || issued_wb) && $onehot0({issued_nrm, issued_wb}));

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe && !burst_rdy) |=> (!strobe && (burst_rdy || !$past(burst_rdy)) ));

   // R11
   always_comb begin
      if (rst) begin
         reset_quiet_chk: assert (!strobe && !strobe_oe);
      end
   end

endmodule

// File: tb/bus_start_seq_test.sv
`timescale 1ns/1ps
module bus_start_seq_test;
   localparam int AW = 32;
   localparam int CW = 4;
   localparam time CYC = 20ns;   // 50 MHz
   localparam logic [AW-1:0] NA  = 32'h1234_5678;
   localparam logic [CW-1:0] ND  = 4'h3;
   localparam logic [AW-1:0] WA  = 32'hABCD_EF7F;
   localparam logic [AW-1:0] WAL = 32'hABCD_EF60;   // low 5 bits cleared
   localparam logic [CW-1:0] WD  = 4'hC;

   // {rst init rn rw rdy ah bo hla hit} , {stb oe gn gw}
   localparam int NV = 54;
   localparam logic [12:0] VEC [NV] = '{
      13'b100000000_0000, 13'b000000000_0100, 13'b001000000_1110, 13'b000000000_0100,
      13'b001000000_0100, 13'b001010000_0100, 13'b001000000_0100, 13'b001000000_1110,
      13'b000010000_0100, 13'b000000000_0100, 13'b000000000_0100, 13'b001001000_0100,
      13'b001001001_0100, 13'b001101001_0100, 13'b001101001_1101, 13'b001011000_0100,
      13'b001001000_0100, 13'b001001000_0100, 13'b001000000_0100, 13'b001000000_1110,
      13'b000010000_0100, 13'b000000000_0100, 13'b000000000_0100, 13'b000000001_0100,
      13'b000000001_0100, 13'b001100001_1101, 13'b000010000_0100, 13'b001000000_0100,
      13'b001000000_1110, 13'b000010000_0100, 13'b000000000_0100, 13'b000000000_0100,
      13'b001000100_0100, 13'b001000100_0000, 13'b001000000_0000, 13'b001000000_1110,
      13'b000010000_0100, 13'b000000000_0100, 13'b000000000_0100, 13'b001000010_0000,
      13'b001000000_0100, 13'b001000000_1110, 13'b000010000_0100, 13'b000000000_0100,
      13'b000000000_0100, 13'b011000000_0100, 13'b001000000_1110, 13'b000010000_0100,
      13'b000000000_0100, 13'b000000000_0100, 13'b001000000_1110, 13'b101000000_0000,
      13'b001000000_1110, 13'b000010000_0100
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cpu_init = 1'b0, req_nrm = 1'b0, req_wb = 1'b0, burst_rdy = 1'b0;
   logic addr_hold = 1'b0, back_off = 1'b0, hold_ack = 1'b0, hit_mod = 1'b0;
   logic strobe, strobe_oe, issued_nrm, issued_wb;
   logic [AW-1:0] bus_addr;
   logic [CW-1:0] bus_def;

   int checks = 0;
   int errors = 0;
   logic [AW-1:0] held_addr = '0;
   logic [CW-1:0] held_def  = '0;

   always #(CYC/2) clk = ~clk;

   bus_start_seq uut (
      .clk(clk), .rst(rst), .cpu_init(cpu_init),
      .req_nrm(req_nrm), .req_wb(req_wb),
      .nrm_addr(NA), .nrm_def(ND), .wb_addr(WA), .wb_def(WD),
      .burst_rdy(burst_rdy), .addr_hold(addr_hold), .back_off(back_off),
      .hold_ack(hold_ack), .hit_mod(hit_mod),
      .strobe(strobe), .strobe_oe(strobe_oe),
      .bus_addr(bus_addr), .bus_def(bus_def),
      .issued_nrm(issued_nrm), .issued_wb(issued_wb)
   );

   function automatic string tag_of(int i);
      if (i <= 1)  return "R11";
      if (i <= 3)  return "R1";
      if (i <= 5)  return "R10";
      if (i <= 10) return "R2";
      if (i <= 13) return "R5";
      if (i == 14) return "R4";
      if (i <= 17) return "R5";
      if (i <= 19) return "R3";
      if (i <= 24) return "R2";
      if (i == 25) return "R9";
      if (i <= 31) return "R2";
      if (i <= 33) return "R7";
      if (i == 34) return "R3";
      if (i == 35) return "R7";
      if (i <= 38) return "R2";
      if (i == 39) return "R7";
      if (i <= 41) return "R3";
      if (i <= 44) return "R2";
      if (i <= 46) return "R6";
      if (i <= 50) return "R2";
      if (i <= 52) return "R11";
      return "R2";
   endfunction

   task automatic step(input logic [8:0] vin, input logic [3:0] vexp, input string tag);
      logic [3:0] got;
      @(negedge clk);
      {rst, cpu_init, req_nrm, req_wb, burst_rdy, addr_hold, back_off, hold_ack, hit_mod} = vin;
      #2;
      got = {strobe, strobe_oe, issued_nrm, issued_wb};
      checks++;
      if (got !== vexp) begin
         errors++;
         $display("FAIL %s: stb/oe/gn/gw actual=%b expected=%b", tag, got, vexp);
      end
      if (vexp[3]) begin
         held_addr = vexp[0] ? WAL : NA;
         held_def  = vexp[0] ? WD  : ND;
      end
      // R8: address and code in the strobe clock and while held
      if (vexp[2]) begin
         checks++;
         if (bus_addr !== held_addr || bus_def !== held_def) begin
            errors++;
            $display("FAIL R8 (%s): addr/def actual=%h/%h expected=%h/%h",
                     tag, bus_addr, bus_def, held_addr, held_def);
         end
      end
      if (vin[8]) begin
         held_addr = '0;
         held_def  = '0;
      end
   endtask

   initial begin
      #(CYC * 5000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][12:4], VEC[i][3:0], tag_of(i));
      end
      // directed: hit spacing from a fresh reset (R4)
      step(9'b100000000, 4'b0000, "R11");
      step(9'b000100001, 4'b0100, "R4");
      step(9'b000100001, 4'b0100, "R4");
      step(9'b000100001, 4'b1101, "R4");
      step(9'b000010000, 4'b0100, "R2");
      // back-off and hold ack block a writeback too (R6)
      step(9'b000100100, 4'b0100, "R6");
      step(9'b000100110, 4'b0000, "R6");
      step(9'b000000010, 4'b0000, "R7");
      step(9'b000100000, 4'b0100, "R3");
      step(9'b000100000, 4'b1101, "R3");
      step(9'b000010000, 4'b0100, "R10");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule